// File: doc/BRIEF.md
# Bank-Switched Threshold Logic Neuron

This block evaluates any one of the sixteen Boolean functions of two inputs, `in_x` and `in_y`, using a small network of hard-limit threshold neurons. A 4-bit function code chooses the function. Each neuron adds a bias to a signed weighted sum of its active inputs. It outputs 1 only when that total is strictly positive.

The top bit of the function code does not feed the network as an extra input. It chooses which of two fixed weight banks drives a shared layer of four hidden summing units. The same choice is made again between the hidden layer and the single output unit. The other three code bits, together with `in_x` and `in_y`, form the five features seen by the hidden units.

Operands are presented with `in_valid`. The result is captured on the next rising clock edge. `out_valid` is then high for exactly one cycle.

Top module: `bank_switched_logic_neuron`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid` is 0 and `result` is 0.
- R2: If `in_valid` is high at a rising edge, `out_valid` is 1 for the following cycle. If `in_valid` is low at an edge, `out_valid` is 0 for the following cycle.
- R3: The captured `result` equals bit `2*in_x + in_y` of `func_code`. So code 4'b1000 is AND, 4'b1110 OR, 4'b0111 NAND, 4'b0001 NOR, 4'b0110 XOR, 4'b1001 XNOR, 4'b1100 passes X, 4'b1010 passes Y, 4'b0011 inverts X, 4'b0101 inverts Y, 4'b0000 and 4'b1111 are constants, and 4'b0010, 4'b0100, 4'b1011 and 4'b1101 are the mixed forms with one input inverted.
- R4: When `in_valid` is low at an edge, `result` keeps its value, whatever `func_code`, `in_x` and `in_y` hold.
- R5: When `in_x` = `in_y` = 1, the result equals `func_code[3]`, the bank-select bit, for every value of the lower code bits.
- R6: Inputs presented with `in_valid` high on consecutive cycles give consecutive `out_valid` pulses. Each pulse carries the result of its own input.
- R7: For any input, at most one hidden summing unit fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| func_code | input | 4 | Function select; bit 3 is the bank select |
| in_x | input | 1 | First Boolean operand |
| in_y | input | 1 | Second Boolean operand |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 1 | Registered network output |

## Verification
The bench builds the block with its default widths: 8-bit weights and a 12-bit accumulator. With these widths every possible sum fits with wide margin, so the 64-pattern input space can be covered exhaustively. That covers both weight banks and every hidden unit pattern, including the x=y=1 corner where no hidden unit fires. Directed cases then cover reset, holding while idle, and back-to-back operands.

// File: rtl/lnn_pkg.sv
package lnn_pkg;

    // Feature vector seen by the hidden units: {code[2:0], x, y}
    localparam int NUM_FEAT   = 5;
    localparam int NUM_HIDDEN = 4;
    localparam int NUM_MINT   = 3;  // minterms covered by hidden units

    typedef enum logic {
        BANK_DIRECT     = 1'b0,
        BANK_COMPLEMENT = 1'b1
    } bank_e;

    typedef struct packed {
        bank_e      bank;
        logic [2:0] sel;
        logic       x;
        logic       y;
    } nn_in_t;

    function automatic logic [NUM_FEAT-1:0] features(input nn_in_t v);
        return {v.sel, v.x, v.y};
    endfunction

    // Hidden weight: unit u detects minterm u (x = u/2, y = u%2) gated by code bit u.
    function automatic int hid_weight(input int bank, input int unit, input int idx);
        int xb;
        int yb;
        if (unit >= NUM_MINT) return 0;
        xb = unit / 2;
        yb = unit % 2;
        if (idx == 0) return (yb != 0) ? 2 : -2;
        if (idx == 1) return (xb != 0) ? 2 : -2;
        if (idx == 2 + unit) return (bank != 0) ? -2 : 2;
        return 0;
    endfunction

    function automatic int hid_bias(input int bank, input int unit);
        int ones;
        if (unit >= NUM_MINT) return -1;
        ones = (unit / 2) + (unit % 2);
        return (bank != 0) ? (1 - 2 * ones) : (-1 - 2 * ones);
    endfunction

    function automatic int out_weight(input int bank, input int unit);
        if (unit >= NUM_MINT) return 0;
        return (bank != 0) ? -1 : 1;
    endfunction

    function automatic int out_bias(input int bank);
        return (bank != 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/threshold_unit.sv
module threshold_unit #(
    parameter int N_IN     = 5,
    parameter int WEIGHT_W = 8,
    parameter int ACC_W    = 12
) (
    input  logic [N_IN-1:0]               act,
    input  logic [N_IN-1:0][WEIGHT_W-1:0] wts,
    input  logic [WEIGHT_W-1:0]           bias,
    output logic                          fire
);
    localparam int EXT_W = ACC_W - WEIGHT_W;

    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = $signed({{EXT_W{bias[WEIGHT_W-1]}}, bias});
        for (int i = 0; i < N_IN; i++) begin
            if (act[i]) begin
                acc = acc + $signed({{EXT_W{wts[i][WEIGHT_W-1]}}, wts[i]});
            end
        end
    end

    assign fire = (acc > 0);

endmodule

// File: rtl/hidden_layer.sv
module hidden_layer #(
    parameter int WEIGHT_W = 8,
    parameter int ACC_W    = 12
) (
    input  lnn_pkg::bank_e                   bank,
    input  logic [lnn_pkg::NUM_FEAT-1:0]     feat,
    output logic [lnn_pkg::NUM_HIDDEN-1:0]   fire
);
    import lnn_pkg::*;

    for (genvar u = 0; u < NUM_HIDDEN; u++) begin : g_unit
        logic [NUM_FEAT-1:0][WEIGHT_W-1:0] w_sel;
        logic [WEIGHT_W-1:0]               b_sel;

        always_comb begin
            for (int i = 0; i < NUM_FEAT; i++) begin
                w_sel[i] = (bank == BANK_COMPLEMENT) ? WEIGHT_W'(hid_weight(1, u, i))
                                                     : WEIGHT_W'(hid_weight(0, u, i));
            end
            b_sel = (bank == BANK_COMPLEMENT) ? WEIGHT_W'(hid_bias(1, u))
                                              : WEIGHT_W'(hid_bias(0, u));
        end

        threshold_unit #(
            .N_IN    (NUM_FEAT),
            .WEIGHT_W(WEIGHT_W),
            .ACC_W   (ACC_W)
        ) u_sum (
            .act (feat),
            .wts (w_sel),
            .bias(b_sel),
            .fire(fire[u])
        );
    end

endmodule

// File: rtl/output_stage.sv
module output_stage #(
    parameter int WEIGHT_W = 8,
    parameter int ACC_W    = 12
) (
    input  lnn_pkg::bank_e                 bank,
    input  logic [lnn_pkg::NUM_HIDDEN-1:0] hid,
    output logic                           fire
);
    import lnn_pkg::*;

    logic [NUM_HIDDEN-1:0][WEIGHT_W-1:0] w_sel;
    logic [WEIGHT_W-1:0]                 b_sel;

    always_comb begin
        for (int i = 0; i < NUM_HIDDEN; i++) begin
            w_sel[i] = (bank == BANK_COMPLEMENT) ? WEIGHT_W'(out_weight(1, i))
                                                 : WEIGHT_W'(out_weight(0, i));
        end
        b_sel = (bank == BANK_COMPLEMENT) ? WEIGHT_W'(out_bias(1))
                                          : WEIGHT_W'(out_bias(0));
    end

    threshold_unit #(
        .N_IN    (NUM_HIDDEN),
        .WEIGHT_W(WEIGHT_W),
        .ACC_W   (ACC_W)
    ) u_sum (
        .act (hid),
        .wts (w_sel),
        .bias(b_sel),
        .fire(fire)
    );

endmodule

// File: rtl/bank_switched_logic_neuron.sv
module bank_switched_logic_neuron #(
    parameter int WEIGHT_W = 8,
    parameter int ACC_W    = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [3:0] func_code,
    input  logic       in_x,
    input  logic       in_y,
    output logic       out_valid,
    output logic       result
);
    import lnn_pkg::*;

    nn_in_t                  vin;
    logic [NUM_HIDDEN-1:0]   hid;
    logic                    net_out;

    always_comb begin
        vin.bank = bank_e'(func_code[3]);
        vin.sel  = func_code[2:0];
        vin.x    = in_x;
        vin.y    = in_y;
    end

    hidden_layer #(
        .WEIGHT_W(WEIGHT_W),
        .ACC_W   (ACC_W)
    ) u_hidden (
        .bank(vin.bank),
        .feat(features(vin)),
        .fire(hid)
    );

    output_stage #(
        .WEIGHT_W(WEIGHT_W),
        .ACC_W   (ACC_W)
    ) u_output (
        .bank(vin.bank),
        .hid (hid),
        .fire(net_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= net_out;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                             // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                           // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));                                      // R4
    AST_TRUTH_BIT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (result == $past(func_code[{in_x, in_y}])));            // R3
    AST_BANK_CORNER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_x && in_y) |=> (result == $past(func_code[3])));     // R5
    AST_ONE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hid));                                                      // R7

endmodule

// File: tb/bank_switched_logic_neuron_tb.sv
`timescale 1ns/1ps
module bank_switched_logic_neuron_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] func_code = 4'd0;
    logic       in_x = 1'b0;
    logic       in_y = 1'b0;
    logic       out_valid;
    logic       result;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_switched_logic_neuron u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(func_code),
        .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .result(result)
    );

    // Walk order over the sixteen function codes
    localparam logic [3:0] ORDER [16] = '{
        4'b1000, 4'b1110, 4'b0111, 4'b0001, 4'b0110, 4'b1001, 4'b1100, 4'b1010,
        4'b0011, 4'b0101, 4'b0000, 4'b1111, 4'b0010, 4'b0100, 4'b1011, 4'b1101
    };

    function automatic logic ref_fn(input logic [3:0] c, input logic x, input logic y);
        case (c)
            4'b0000: return 1'b0;
            4'b0001: return ~(x | y);
            4'b0010: return ~x & y;
            4'b0011: return ~x;
            4'b0100: return x & ~y;
            4'b0101: return ~y;
            4'b0110: return x ^ y;
            4'b0111: return ~(x & y);
            4'b1000: return x & y;
            4'b1001: return ~(x ^ y);
            4'b1010: return y;
            4'b1011: return ~x | y;
            4'b1100: return x;
            4'b1101: return x | ~y;
            4'b1110: return x | y;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one operand set, then check at the negedge after the capturing edge
    task automatic apply(input string req, input logic [3:0] c, input logic x, input logic y);
        @(negedge clk);
        func_code = c; in_x = x; in_y = y; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, out_valid, 1'b1);
        chk({req, " result"}, result, ref_fn(c, x, y));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic held;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", out_valid, 1'b0);
        chk("R1 reset result", result, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 post-reset valid", out_valid, 1'b0);
        chk("R1 post-reset result", result, 1'b0);

        // R3: exhaustive walk of all 64 patterns
        for (int k = 0; k < 16; k++) begin
            for (int p = 0; p < 4; p++) begin
                apply("R3", ORDER[k], p[1], p[0]);
            end
        end

        // R5: x=y=1 follows the bank bit regardless of lower code bits
        for (int lo = 0; lo < 8; lo++) begin
            apply("R5 bank0", {1'b0, lo[2:0]}, 1'b1, 1'b1);
            apply("R5 bank1", {1'b1, lo[2:0]}, 1'b1, 1'b1);
        end

        // R4 / R2: idle inputs change nothing
        apply("R4 setup", 4'b1000, 1'b1, 1'b1);
        held = result;
        @(negedge clk);
        func_code = 4'b0000; in_x = 1'b0; in_y = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 hold", result, held);
        chk("R2 idle valid", out_valid, 1'b0);

        // R6: back-to-back operands
        @(negedge clk);
        func_code = 4'b0110; in_x = 1'b1; in_y = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        chk("R6 first valid", out_valid, 1'b1);
        chk("R6 first result", result, 1'b1);
        func_code = 4'b0110; in_x = 1'b1; in_y = 1'b1;
        @(negedge clk);
        chk("R6 second valid", out_valid, 1'b1);
        chk("R6 second result", result, 1'b0);
        func_code = 4'b0001; in_x = 1'b0; in_y = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 third valid", out_valid, 1'b1);
        chk("R6 third result", result, 1'b1);
        @(negedge clk);
        chk("R2 pulse ends", out_valid, 1'b0);

        // R1: reset mid-run clears a held 1
        apply("R1 setup", 4'b1111, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset result", result, 1'b0);
        chk("R1 mid reset valid", out_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule